// File: doc/BRIEF.md
# Masked RGB Bar Pixel Generator

This block turns a pair of bit masks per colour into a three-bit RGB pixel stream for each active video line. Every line carries 40 pixel columns. Each colour channel owns a 40-bit column mask and a 40-bit row mask. A colour is lit at a given pixel only when the column bit and the current row's bit are both set, so crossing bars, boxes and checker patterns come from a handful of mask bytes. Rows are stretched vertically: one row index covers six scan lines.

Line timing comes from outside. A line-start strobe marks each scan line. A window flag says whether the line is inside the picture. A render-start strobe starts the pixel sequence, and a pixel enable paces it. Mask bytes are written through a small write port into a staging copy. The staging copy moves into the working copy only at a line start, so a line is never drawn from a half-updated mask. A frame-done strobe drives an automatic rotation of the green and blue column masks on every second frame, in a direction chosen by an input.

Top module: `rgb_bar_gen`

## Requirements
- R1: The 40 columns are sent left to right. Column c uses the bit at position 7-(c mod 8) of column-mask byte c/8, so bit 7 of byte 0 is the leftmost column. Each column is held for 8 pixel-enable cycles. On `rgb`, bit 0 is red, bit 1 is green and bit 2 is blue. `rgb` is registered and lags the sequencer state by one clock.
- R2: A colour is 1 only when its column-mask bit for the current column and its row-mask bit for the current row are both 1. Otherwise it is 0, and each channel is evaluated on its own.
- R3: The row index is 0 on the first line of a window, meaning a line start with the window flag high after a line start with it low. It then advances by one every 6 window lines. Row r uses the bit at position 7-(r mod 8) of row-mask byte r/8. The row saturates at 40, and rows of 40 and above are dark.
- R4: After the 40th column, `rgb` stays 0 until the next render-start strobe.
- R5: `rgb` is 0 on any cycle following one where `win` is low. Within a line, `rgb` is also 0 before the render-start strobe has been taken.
- R6: On every second `frame_done` pulse with `rot_rev` = 0, the green and blue column masks rotate one column to the right, and the rightmost column wraps to the leftmost. The red column mask never rotates.
- R7: With `rot_rev` = 1, that rotation goes one column to the left, and the leftmost column wraps to the rightmost.
- R8: A write with `wr_en` = 1 stores `wr_data` into byte `wr_idx` (0 to 4) of a staging mask. `wr_ch` selects the channel (0 red, 1 green, 2 blue) and `wr_vert` selects the row mask (1) or the column mask (0). Staged values are used only from the next line start. A `wr_idx` above 4 or a `wr_ch` of 3 changes nothing.
- R9: After reset all masks, the row state, the frame count and `rgb` are 0.
- R10: While `pix_en` is low, the sequencer holds its column and hold count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win | input | 1 | Line lies inside the picture window |
| line_start | input | 1 | One-cycle strobe at the start of each scan line |
| render_start | input | 1 | One-cycle strobe that starts the pixel sequence |
| pix_en | input | 1 | Pixel pacing enable |
| frame_done | input | 1 | One-cycle strobe at the end of each frame |
| rot_rev | input | 1 | Rotation direction: 0 right, 1 left |
| wr_en | input | 1 | Mask byte write strobe |
| wr_vert | input | 1 | 1 writes the row mask, 0 writes the column mask |
| wr_ch | input | 2 | Channel: 0 red, 1 green, 2 blue |
| wr_idx | input | 3 | Byte index within the 40-bit mask |
| wr_data | input | 8 | Byte written |
| rgb | output | 3 | Registered pixel: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The assertions assume that `win` changes only together with a line-start strobe. They also assume that `line_start` and `render_start` never arrive in the same cycle, and that `frame_done` does not arrive in the same cycle as a write to the column mask it would rotate. The stimulus keeps to these rules. It raises `render_start` two cycles after each line start, sets the window flag only in the line-start cycle, and issues frame pulses only while the write port is idle. Mid-line writes are placed deep inside a line, so the deferral to the next line start can be seen on the output.

// File: rtl/rgbbar_pkg.sv
// Package: shared channel encoding for the RGB bar pixel generator.
// Assumes channel codes match the wr_ch port encoding and the rgb bit order.
package rgbbar_pkg;
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } chan_e;
endpackage

// File: rtl/bar_row_tracker.sv
// Module: tracks the vertical row index over the window lines.
// Row 0 is taken on the first window line. The row then steps once every
// VSCALE+1 lines and saturates at NROW. Assumes win changes only together
// with line_start.
module bar_row_tracker #(
    parameter int NROW   = 40,
    parameter int VSCALE = 5,
    localparam int RW    = $clog2(NROW + 1),
    localparam int SW    = $clog2(VSCALE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          win,
    output logic [RW-1:0] row,
    output logic          row_ok
);
    logic          prev_win;
    logic [SW-1:0] vcnt;

    // Update the row state once per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_win <= 1'b0;
            vcnt     <= '0;
            row      <= '0;
        end else if (line_start) begin
            prev_win <= win;
            if (win) begin
                if (!prev_win) begin
                    row  <= '0;
                    vcnt <= SW'(VSCALE);
                end else if (vcnt == '0) begin
                    vcnt <= SW'(VSCALE);
                    if (row != RW'(NROW)) row <= row + RW'(1);
                end else begin
                    vcnt <= vcnt - SW'(1);
                end
            end
        end
    end

    // Rows at or past NROW are dark
    always_comb row_ok = (row < RW'(NROW));

    p_row_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && win && !prev_win) |=> (row == '0));

    p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && win && prev_win && vcnt != '0) |=> $stable(row));
endmodule

// File: rtl/bar_pixel_seq.sv
// Module: steps the column index across one line.
// Each column lasts HOLD pixel-enable cycles. The sequence stops after
// column NPIX-1. Assumes line_start and render_start are never in the same cycle.
module bar_pixel_seq #(
    parameter int NPIX = 40,
    parameter int HOLD = 8,
    localparam int CW  = $clog2(NPIX),
    localparam int HW  = $clog2(HOLD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic          render_start,
    input  logic          win,
    input  logic          pix_en,
    output logic          active,
    output logic [CW-1:0] col
);
    logic [HW-1:0] hold;

    // Column and hold counters for the running line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            col    <= '0;
            hold   <= '0;
        end else if (line_start) begin
            active <= 1'b0;
        end else if (render_start && win) begin
            active <= 1'b1;
            col    <= '0;
            hold   <= '0;
        end else if (active && pix_en) begin
            if (hold == HW'(HOLD - 1)) begin
                hold <= '0;
                if (col == CW'(NPIX - 1)) active <= 1'b0;
                else                      col    <= col + CW'(1);
            end else begin
                hold <= hold + HW'(1);
            end
        end
    end

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pix_en && !line_start && !render_start)
        |=> (active && $stable(col) && $stable(hold)));
endmodule

// File: rtl/bar_mask_bank.sv
// Module: the staged and working column and row masks of one colour channel.
// Writes land in the staged copy, and line_start copies it to the working copy.
// The green and blue column masks rotate on rot_tick. A write to the same
// column mask in that cycle takes priority. Bit NPIX-1 is column/row 0.
module bar_mask_bank #(
    parameter int NPIX = 40,
    parameter rgbbar_pkg::chan_e CH = rgbbar_pkg::CH_RED,
    localparam int NBYTE = NPIX / 8,
    localparam int IW    = $clog2(NBYTE),
    localparam int CW    = $clog2(NPIX),
    localparam int RW    = $clog2(NPIX + 1),
    localparam bit ROTATES = (CH != rgbbar_pkg::CH_RED)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_vert,
    input  logic [1:0]    wr_ch,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          rot_tick,
    input  logic          rot_rev,
    input  logic          line_start,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    input  logic          row_ok,
    output logic          pix_bit
);
    logic [NPIX-1:0] h_stg, v_stg, h_act, v_act;
    logic            hit_h, hit_v;
    logic [CW-1:0]   cidx, ridx;

    always_comb begin
        hit_h = wr_en && !wr_vert && (wr_ch == CH);
        hit_v = wr_en &&  wr_vert && (wr_ch == CH);
    end

    // Staged masks: byte writes and the frame rotation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_stg <= '0;
            v_stg <= '0;
        end else begin
            if (hit_h) begin
                for (int b = 0; b < NBYTE; b++)
                    if (wr_idx == IW'(b)) h_stg[NPIX-1-8*b -: 8] <= wr_data;
            end else if (ROTATES && rot_tick) begin
                h_stg <= rot_rev ? {h_stg[NPIX-2:0], h_stg[NPIX-1]}
                                 : {h_stg[0], h_stg[NPIX-1:1]};
            end
            if (hit_v) begin
                for (int b = 0; b < NBYTE; b++)
                    if (wr_idx == IW'(b)) v_stg[NPIX-1-8*b -: 8] <= wr_data;
            end
        end
    end

    // Working masks follow the staged masks at each line start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_act <= '0;
            v_act <= '0;
        end else if (line_start) begin
            h_act <= h_stg;
            v_act <= v_stg;
        end
    end

    // Pick the column and row bits and combine them
    always_comb begin
        cidx    = CW'(NPIX - 1) - col;
        ridx    = CW'(NPIX - 1) - row[CW-1:0];
        pix_bit = h_act[cidx] && row_ok && v_act[ridx];
    end

    p_rot_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_tick && !hit_h) |=> ($countones(h_stg) == $countones($past(h_stg))));

    p_act_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> ($stable(h_act) && $stable(v_act)));

    if (!ROTATES) begin : g_fixed
        p_red_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rot_tick && !hit_h) |=> $stable(h_stg));
    end
endmodule

// File: rtl/rgb_bar_gen.sv
// Module: top of the masked RGB bar pixel generator.
// It counts frames for the rotation, tracks rows, sequences columns and
// registers the three colour bits. Assumes NPIX is a multiple of 8.
module rgb_bar_gen #(
    parameter int NPIX       = 40,
    parameter int PIX_HOLD   = 8,
    parameter int VSCALE     = 5,
    parameter int ROT_FRAMES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      win,
    input  logic                      line_start,
    input  logic                      render_start,
    input  logic                      pix_en,
    input  logic                      frame_done,
    input  logic                      rot_rev,
    input  logic                      wr_en,
    input  logic                      wr_vert,
    input  logic [1:0]                wr_ch,
    input  logic [$clog2(NPIX/8)-1:0] wr_idx,
    input  logic [7:0]                wr_data,
    output logic [2:0]                rgb
);
    localparam int CW = $clog2(NPIX);
    localparam int RW = $clog2(NPIX + 1);
    localparam int FW = $clog2(ROT_FRAMES + 1);

    logic [FW-1:0] fcnt;
    logic          rot_tick;
    logic [RW-1:0] row;
    logic          row_ok;
    logic          seq_active;
    logic [CW-1:0] col;
    logic [2:0]    pix;

    always_comb rot_tick = frame_done && (fcnt == FW'(ROT_FRAMES - 1));

    // Frame counter that paces the mask rotation
    always_ff @(posedge clk) begin
        if (!rst_n)          fcnt <= '0;
        else if (rot_tick)   fcnt <= '0;
        else if (frame_done) fcnt <= fcnt + FW'(1);
    end

    bar_row_tracker #(.NROW(NPIX), .VSCALE(VSCALE)) u_rows (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .win(win),
        .row(row), .row_ok(row_ok)
    );

    bar_pixel_seq #(.NPIX(NPIX), .HOLD(PIX_HOLD)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .render_start(render_start), .win(win), .pix_en(pix_en),
        .active(seq_active), .col(col)
    );

    for (genvar c = 0; c < 3; c++) begin : g_ch
        bar_mask_bank #(.NPIX(NPIX), .CH(rgbbar_pkg::chan_e'(c))) u_bank (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_vert(wr_vert),
            .wr_ch(wr_ch), .wr_idx(wr_idx), .wr_data(wr_data),
            .rot_tick(rot_tick), .rot_rev(rot_rev), .line_start(line_start),
            .col(col), .row(row), .row_ok(row_ok), .pix_bit(pix[c])
        );
    end

    // Registered pixel output, dark outside the window or the sequence
    always_ff @(posedge clk) begin
        if (!rst_n) rgb <= '0;
        else        rgb <= (seq_active && win) ? pix : 3'b000;
    end

    p_dark_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !win |=> (rgb == 3'b000));

    p_dark_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_active |=> (rgb == 3'b000));
endmodule

// File: tb/test_rgb_bar_gen.sv
`timescale 1ns/1ps
module test_rgb_bar_gen;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       win = 0, line_start = 0, render_start = 0, pix_en = 0;
    logic       frame_done = 0, rot_rev = 0, wr_en = 0, wr_vert = 0;
    logic [1:0] wr_ch = 0;
    logic [2:0] wr_idx = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] rgb;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model: staged and working masks, row state, frame count
    logic [39:0] hs [3], vs [3], hm [3], vm [3];
    int  rowm = 0, vcm = 0, fcount = 0;
    bit  pwin = 0, cur_win = 0;

    // Table entries: {red col, green col, blue col, red row, green row, blue row}
    localparam logic [239:0] VEC [4] = '{
        {40'hFF00FF00FF, 40'h0F0F0F0F0F, 40'h8000000001,
         40'hFFFFFFFFFF, 40'hA000000000, 40'h6000000000},
        {40'h123456789A, 40'hFFFFFFFFFF, 40'h0000000000,
         40'h4000000000, 40'hE000000000, 40'h0000000000},
        {40'h0000000000, 40'hF0F0F0F0F0, 40'hAAAAAAAAAA,
         40'h0000000000, 40'h2000000000, 40'hC000000000},
        {40'hFFFFFFFFFF, 40'h5555555555, 40'hFFFFFFFFFF,
         40'h8000000000, 40'hC000000000, 40'hA000000000}
    };

    rgb_bar_gen i_rgb_bar_gen (
        .clk(clk), .rst_n(rst_n), .win(win), .line_start(line_start),
        .render_start(render_start), .pix_en(pix_en), .frame_done(frame_done),
        .rot_rev(rot_rev), .wr_en(wr_en), .wr_vert(wr_vert), .wr_ch(wr_ch),
        .wr_idx(wr_idx), .wr_data(wr_data), .rgb(rgb)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: rgb=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_pix(input int c);
        logic [2:0] p;
        for (int k = 0; k < 3; k++)
            p[k] = cur_win && hm[k][39-c] && (rowm < 40) && vm[k][39-rowm];
        return p;
    endfunction

    task automatic wr(input bit vert, input int ch, input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_vert = vert; wr_ch = 2'(ch); wr_idx = 3'(idx); wr_data = d;
        if (ch < 3 && idx < 5) begin
            if (vert) vs[ch][39-8*idx -: 8] = d;
            else      hs[ch][39-8*idx -: 8] = d;
        end
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic load(input bit vert, input int ch, input logic [39:0] v);
        for (int b = 0; b < 5; b++) wr(vert, ch, b, v[39-8*b -: 8]);
    endtask

    task automatic frame();
        @(negedge clk); frame_done = 1;
        fcount++;
        if (fcount == 2) begin
            fcount = 0;
            for (int k = 1; k < 3; k++)
                hs[k] = rot_rev ? {hs[k][38:0], hs[k][39]} : {hs[k][0], hs[k][39:1]};
        end
        @(negedge clk); frame_done = 0;
    endtask

    // One scan line: line start, render start two cycles later, 40 columns
    task automatic do_line(input bit w, input bit slow, input bit midwr, input string tag);
        int n, pp;
        bit pe;
        @(negedge clk);
        line_start = 1; win = w; cur_win = w;
        for (int k = 0; k < 3; k++) begin hm[k] = hs[k]; vm[k] = vs[k]; end
        if (w) begin
            if (!pwin) begin rowm = 0; vcm = 5; end
            else if (vcm == 0) begin vcm = 5; if (rowm < 40) rowm++; end
            else vcm--;
        end
        pwin = w;
        @(negedge clk); line_start = 0;
        chk({tag, " R5 before render start"}, rgb, 3'b000);
        @(negedge clk); render_start = 1;
        @(negedge clk); render_start = 0;
        n = 0; pp = 0;
        while (1) begin
            pe = slow ? (n % 2 == 0) : 1'b1;
            pix_en = pe;
            @(negedge clk);
            n++;
            if (pp >= 320) begin
                chk({tag, " R4 after last column"}, rgb, 3'b000);
                break;
            end
            if (pp % 8 == 4) chk({tag, " R1 R2 pixel"}, rgb, exp_pix(pp / 8));
            if (pe) pp++;
            if (midwr && n == 100) begin
                wr_en = 1; wr_vert = 0; wr_ch = 0; wr_idx = 3'd4; wr_data = 8'h3C;
                hs[0][7:0] = 8'h3C;
            end
            if (n == 101) wr_en = 0;
        end
        pix_en = 0;
    endtask

    initial begin
        #(4 * 195000);
        checks++; errors++;
        $display("FAIL (all requirements): watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin hs[k] = '0; vs[k] = '0; hm[k] = '0; vm[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 reset output", rgb, 3'b000);
        // R9: masks are zero after reset, so a window line is dark
        do_line(1, 0, 0, "R9 zero masks");
        do_line(0, 0, 0, "R5 gap");

        // Table walk: load all masks, then render rows 0..2 (R1 R2 R3)
        for (int e = 0; e < 4; e++) begin
            for (int k = 0; k < 3; k++) begin
                load(0, k, VEC[e][239-40*k -: 40]);
                load(1, k, VEC[e][119-40*k -: 40]);
            end
            do_line(0, 0, 0, "R5 outside window");
            for (int l = 0; l < 13; l++) do_line(1, 0, 0, "R3 table");
        end

        // R8: out-of-range index and channel 3 change nothing
        wr(0, 0, 5, 8'h00);
        wr(0, 3, 0, 8'h00);
        wr(1, 3, 1, 8'hFF);
        do_line(1, 0, 0, "R8 ignored writes");
        // R8: a write in the middle of a line waits for the next line
        do_line(1, 0, 1, "R8 mid-line write");
        do_line(1, 0, 0, "R8 staged write used");
        // R10: pixel enable low every other cycle stretches the line
        do_line(1, 1, 0, "R10 stalled line");
        do_line(0, 0, 0, "R5 window low");

        // R6/R7: rotation of green and blue, red fixed
        load(0, 0, 40'hC000000000);
        load(0, 1, 40'h8000000000);
        load(0, 2, 40'h0400000000);
        for (int k = 0; k < 3; k++) load(1, k, 40'hFFFFFFFFFF);
        rot_rev = 0;
        frame(); do_line(0, 0, 0, "R6 gap"); do_line(1, 0, 0, "R6 one frame");
        frame(); do_line(1, 0, 0, "R6 rotate right");
        frame(); frame(); do_line(1, 0, 0, "R6 rotate right twice");
        rot_rev = 1;
        frame(); frame(); do_line(1, 0, 0, "R7 rotate left");
        frame(); frame(); do_line(1, 0, 0, "R7 back to start");
        frame(); frame(); do_line(1, 0, 0, "R7 left wrap");

        // R3: only row 39 lit; rows saturate at 40 and stay dark
        for (int k = 0; k < 3; k++) begin
            load(0, k, 40'hFFFFFFFFFF);
            load(1, k, 40'h0000000001);
        end
        do_line(0, 0, 0, "R3 gap");
        for (int l = 0; l < 246; l++) do_line(1, 0, 0, "R3 long window");
        do_line(0, 0, 0, "R5 end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule